// File: doc/BRIEF.md
# Watchdog Timer with Overflow and Reset Pulses

This block is an 8-bit up-counting watchdog. The counter advances on a single-cycle tick input, which comes from a prescaler outside the block. Software keeps the system alive by rewriting the counter, normally with zero, before it reaches its last value.

The block signals a failure only when the watchdog-mode bit and the run bit are both 1. In that case the overflow makes the counter wrap, and the block drives an active-low alarm pulse of fixed length. If the reset-enable bit is also set, the block drives an active-high internal reset pulse that starts in the same cycle and lasts longer. The block latches an overflow flag, and that flag survives the internal reset. The block's own reset input stands for the external reset pin. It has priority over everything and clears all state, the flag included.

Software reaches the block through a one-bit-address register port. The read path is combinational: `rdata` follows `addr` in the same cycle.

Top module: `wdog_top`

## Requirements
- R1: After reset, the counter reads 0x00, the control register reads 0x00, `wdt_ovf_n` is 1 and `int_rst` is 0.
- R2: Address 0 is the control register: bit 7 is the overflow flag, bit 6 is watchdog mode, bit 5 is run and bit 4 is reset-enable. Bits 3..0 read as 0. Address 1 reads and writes the counter.
- R3: Each cycle with `tick`=1 and run=1 adds one to the counter. With run=0, or with no tick, the counter holds its value. Watchdog mode alone does not make it count.
- R4: A counter write loads `wdata`. In a cycle that has both a counter write and a tick, the written value wins.
- R5: A tick at count 0xFF with watchdog mode=1 and run=1 wraps the counter to 0x00 and pulls `wdt_ovf_n` low from the following cycle.
- R6: `wdt_ovf_n` stays low for 133 cycles when reset-enable was 1 at the overflow, and for 130 cycles when it was 0.
- R7: With reset-enable=1, `int_rst` goes high in the same cycle as `wdt_ovf_n` falls and stays high for 519 cycles. With reset-enable=0, `int_rst` stays 0.
- R8: A wrap with watchdog mode=0 produces no pulse and does not set the flag.
- R9: A watchdog overflow sets the flag. The flag stays set through the internal reset pulse. Writing 1 to bit 7 never sets it.
- R10: The flag clears only when a control write with bit 7=0 follows a control read that returned the flag as 1. A write of 0 without that read leaves the flag set.
- R11: Asserting `rst_n` clears the counter, the control bits and the flag, and ends any pulse at once. This also holds when `rst_n` coincides with an overflow tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | External reset, active low, asynchronous |
| tick | input | 1 | One-cycle prescaler count enable |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (arms flag clearing) |
| addr | input | 1 | 0 = control/status, 1 = counter |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, follows addr combinationally |
| wdt_ovf_n | output | 1 | Overflow alarm pulse, active low |
| int_rst | output | 1 | Internal reset pulse, active high |

## Verification
The embedded assertions check on every cycle several fixed relationships:
- the counter steps by one on each tick, holds without one, and takes a written value;
- a pulse timer counts down by exactly one per cycle once loaded;
- the alarm never falls without a watchdog overflow one cycle earlier;
- `int_rst` never rises while the alarm is inactive;
- the flag is set after every overflow and never drops without an armed write of 0.

Only the bench scenarios can show the absolute pulse lengths of 130, 133 and 519 cycles. The same holds for the read-then-write ordering that flag clearing needs, and for the outcome of a reset that lands on an overflow tick or in the middle of a pulse.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int CNT_W  = 8;
  localparam int DATA_W = 8;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_CNT  = 1'b1;

  localparam int FLAG_BIT  = 7;
  localparam int MODE_BIT  = 6;
  localparam int RUN_BIT   = 5;
  localparam int RSTEN_BIT = 4;

  typedef struct packed {
    logic flag;
    logic wd_mode;
    logic run;
    logic rst_en;
  } wdog_ctrl_t;

  function automatic logic [DATA_W-1:0] ctrl_pack(input wdog_ctrl_t c);
    logic [DATA_W-1:0] v;
    v = '0;
    v[FLAG_BIT]  = c.flag;
    v[MODE_BIT]  = c.wd_mode;
    v[RUN_BIT]   = c.run;
    v[RSTEN_BIT] = c.rst_en;
    return v;
  endfunction

  function automatic logic [CNT_W-1:0] cnt_next(input logic [CNT_W-1:0] c);
    return c + CNT_W'(1);
  endfunction

  function automatic logic cnt_is_last(input logic [CNT_W-1:0] c);
    return &c;
  endfunction

  function automatic int ovf_pulse_len(input logic rst_en, input int with_rst,
                                       input int without_rst);
    return rst_en ? with_rst : without_rst;
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  input  logic         run,
  output logic [W-1:0] cnt,
  output logic         wrap
);

  logic step;
  assign step = tick && run && !load;
  assign wrap = step && (&cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (load)   cnt <= load_val;
    else if (step)   cnt <= cnt + W'(1);
  end

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && !load) |=> cnt == W'($past(cnt) + W'(1)));

  assert_count_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !(tick && run)) |=> $stable(cnt));

  assert_load_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt == $past(load_val));

endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  output logic             active
);

  logic [LEN_W-1:0] remaining;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                remaining <= '0;
    else if (start)            remaining <= len;
    else if (remaining != '0)  remaining <= remaining - LEN_W'(1);
  end

  assign active = (remaining != '0);

  assert_pulse_starts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && len != '0) |=> active);

  assert_pulse_countdown_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !start) |=> remaining == LEN_W'($past(remaining) - LEN_W'(1)));

endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic       addr,
  input  logic [3:0] wr_hi,
  input  logic       wd_ovf,
  output wdog_ctrl_t ctrl
);

  logic wr_ctrl, rd_ctrl, armed, clr_flag;

  assign wr_ctrl  = wr_en && (addr == ADDR_CTRL);
  assign rd_ctrl  = rd_en && (addr == ADDR_CTRL);
  assign clr_flag = wr_ctrl && armed && !wr_hi[FLAG_BIT-4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl.wd_mode <= 1'b0;
      ctrl.run     <= 1'b0;
      ctrl.rst_en  <= 1'b0;
    end else if (wr_ctrl) begin
      ctrl.wd_mode <= wr_hi[MODE_BIT-4];
      ctrl.run     <= wr_hi[RUN_BIT-4];
      ctrl.rst_en  <= wr_hi[RSTEN_BIT-4];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ctrl.flag <= 1'b0;
    else if (wd_ovf)   ctrl.flag <= 1'b1;
    else if (clr_flag) ctrl.flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   armed <= 1'b0;
    else if (wr_ctrl)             armed <= 1'b0;
    else if (rd_ctrl && ctrl.flag) armed <= 1'b1;
  end

  assert_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wd_ovf |=> ctrl.flag);

  assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl.flag) |-> ($past(wr_en) && $past(addr) == ADDR_CTRL
                          && !$past(wr_hi[FLAG_BIT-4])));

endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int OVF_LEN_RST   = 133,
  parameter int OVF_LEN_NORST = 130,
  parameter int IRST_LEN      = 519
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              wdt_ovf_n,
  output logic              int_rst
);

  localparam int LEN_MAX = max_int(max_int(OVF_LEN_RST, OVF_LEN_NORST), IRST_LEN);
  localparam int LEN_W   = $clog2(LEN_MAX + 1);

  wdog_ctrl_t       ctrl;
  logic [CNT_W-1:0] cnt;
  logic             cnt_load, wrap, wd_ovf, irst_start;
  logic             ovf_active, irst_active;
  logic [LEN_W-1:0] ovf_len, irst_len;

  assign cnt_load   = wr_en && (addr == ADDR_CNT);
  assign wd_ovf     = wrap && ctrl.wd_mode;
  assign irst_start = wd_ovf && ctrl.rst_en;
  assign ovf_len    = LEN_W'(ovf_pulse_len(ctrl.rst_en, OVF_LEN_RST, OVF_LEN_NORST));
  assign irst_len   = LEN_W'(IRST_LEN);

  wdog_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .addr   (addr),
    .wr_hi  (wdata[7:4]),
    .wd_ovf (wd_ovf),
    .ctrl   (ctrl)
  );

  wdog_count #(.W(CNT_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (wdata),
    .tick     (tick),
    .run      (ctrl.run),
    .cnt      (cnt),
    .wrap     (wrap)
  );

  wdog_pulse #(.LEN_W(LEN_W)) u_ovf_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (wd_ovf),
    .len    (ovf_len),
    .active (ovf_active)
  );

  wdog_pulse #(.LEN_W(LEN_W)) u_irst_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (irst_start),
    .len    (irst_len),
    .active (irst_active)
  );

  assign rdata     = (addr == ADDR_CNT) ? cnt : ctrl_pack(ctrl);
  assign wdt_ovf_n = !ovf_active;
  assign int_rst   = irst_active;

  assert_ovf_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdt_ovf_n) |-> $past(wd_ovf));

  assert_wrap_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wd_ovf |=> (cnt == '0 || $past(cnt_load)));

  assert_irst_with_ovf_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_rst) |-> !wdt_ovf_n);

  assert_no_pulse_mode_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !ctrl.wd_mode && wdt_ovf_n) |=> wdt_ovf_n);

endmodule

// File: tb/wdog_top_bench.sv
`timescale 1ns/1ps
module wdog_top_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       wdt_ovf_n, int_rst;

  int checks = 0, fails = 0;
  int low_seen = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wdog_top u_wdog_top (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .wdt_ovf_n(wdt_ovf_n), .int_rst(int_rst)
  );

  always @(negedge clk) if (!wdt_ovf_n) low_seen++;

  typedef struct packed {
    logic [7:0] ctl;
    logic [7:0] pre;
    logic [8:0] ticks;
    logic [7:0] exp_cnt;
    logic       exp_flag;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{8'h20, 8'h00, 9'd5,   8'h05, 1'b0},
    '{8'h00, 8'h10, 9'd7,   8'h10, 1'b0},
    '{8'h40, 8'hFE, 9'd4,   8'hFE, 1'b0},
    '{8'h20, 8'hFD, 9'd5,   8'h02, 1'b0},
    '{8'h60, 8'h80, 9'd20,  8'h94, 1'b0},
    '{8'h20, 8'hF0, 9'd256, 8'hF0, 1'b0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  // Loads the counter with 0xFF and gives one tick; returns at the first negedge after the overflow edge.
  task automatic trigger(input logic [7:0] ctl);
    bus_wr(1'b1, 8'hFF);
    bus_wr(1'b0, ctl);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic measure(output int lo, output int ir);
    lo = 0; ir = 0;
    for (int i = 0; i < 700; i++) begin
      if (!wdt_ovf_n) lo++;
      if (int_rst) ir++;
      @(negedge clk);
    end
  endtask

  initial begin
    logic [7:0] d;
    int lo, ir;

    do_reset();
    // R1 reset state
    check(wdt_ovf_n === 1'b1, "R1 ovf_n", wdt_ovf_n, 1);
    check(int_rst === 1'b0, "R1 int_rst", int_rst, 0);
    bus_rd(1'b0, d); check(d === 8'h00, "R1 ctrl", d, 8'h00);
    bus_rd(1'b1, d); check(d === 8'h00, "R1 cnt", d, 8'h00);

    // R2 / R9 layout: low bits read 0, flag cannot be written to 1
    bus_wr(1'b0, 8'hFF);
    bus_rd(1'b0, d); check(d === 8'h70, "R2 R9 ctrl layout", d, 8'h70);
    bus_wr(1'b0, 8'h00);

    // Table walk: R3 counting and R8 wrap without watchdog mode
    for (int v = 0; v < NV; v++) begin
      low_seen = 0;
      bus_wr(1'b0, VECS[v].ctl);
      bus_wr(1'b1, VECS[v].pre);
      ticks(int'(VECS[v].ticks));
      bus_rd(1'b1, d);
      check(d === VECS[v].exp_cnt, "R3 R8 table count", d, VECS[v].exp_cnt);
      bus_rd(1'b0, d);
      check(d[7] === VECS[v].exp_flag, "R8 table flag", d[7], VECS[v].exp_flag);
      check(low_seen == 0, "R8 table no alarm", low_seen, 0);
    end

    // R4 write wins over a tick in the same cycle
    bus_wr(1'b0, 8'h20);
    bus_wr(1'b1, 8'h10);
    @(negedge clk); wr_en = 1'b1; addr = 1'b1; wdata = 8'h33; tick = 1'b1;
    @(negedge clk); wr_en = 1'b0; tick = 1'b0;
    bus_rd(1'b1, d); check(d === 8'h33, "R4 write beats tick", d, 8'h33);

    // R5 R6 R7 R9 with reset-enable set
    do_reset();
    trigger(8'h70);
    check(wdt_ovf_n === 1'b0, "R5 alarm starts", wdt_ovf_n, 0);
    check(int_rst === 1'b1, "R7 same start", int_rst, 1);
    measure(lo, ir);
    check(lo == 133, "R6 alarm len rst_en=1", lo, 133);
    check(ir == 519, "R7 int_rst len", ir, 519);
    bus_rd(1'b1, d); check(d === 8'h00, "R5 wrapped to zero", d, 8'h00);

    // R10 write 0 without prior read keeps flag; R9 flag survives the pulse
    bus_wr(1'b0, 8'h60);
    bus_rd(1'b0, d); check(d === 8'hE0, "R9 R10 flag kept", d, 8'hE0);
    bus_wr(1'b0, 8'h00);
    bus_rd(1'b0, d); check(d === 8'h00, "R10 flag cleared after read", d, 8'h00);

    // R6 R7 reset-enable clear
    trigger(8'h60);
    check(wdt_ovf_n === 1'b0, "R5 alarm starts", wdt_ovf_n, 0);
    measure(lo, ir);
    check(lo == 130, "R6 alarm len rst_en=0", lo, 130);
    check(ir == 0, "R7 no int_rst", ir, 0);
    bus_rd(1'b0, d); check(d[7] === 1'b1, "R9 flag set", d[7], 1);

    // R11 reset in the middle of a pulse
    trigger(8'h70);
    repeat (40) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(wdt_ovf_n === 1'b1, "R11 alarm cut", wdt_ovf_n, 1);
    check(int_rst === 1'b0, "R11 int_rst cut", int_rst, 0);
    @(negedge clk); rst_n = 1'b1;
    bus_rd(1'b0, d); check(d === 8'h00, "R11 ctrl cleared", d, 8'h00);
    bus_rd(1'b1, d); check(d === 8'h00, "R11 cnt cleared", d, 8'h00);

    // R11 reset coinciding with an overflow tick
    bus_wr(1'b1, 8'hFF);
    bus_wr(1'b0, 8'h70);
    @(negedge clk); tick = 1'b1; rst_n = 1'b0;
    @(negedge clk); tick = 1'b0; rst_n = 1'b1;
    check(wdt_ovf_n === 1'b1, "R11 coincident no alarm", wdt_ovf_n, 1);
    check(int_rst === 1'b0, "R11 coincident no int_rst", int_rst, 0);
    bus_rd(1'b0, d); check(d === 8'h00, "R11 coincident flag clear", d, 8'h00);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule